// File: doc/BRIEF.md
# Instruction Control Decoder

This block is the main control unit of a 64-bit load/store teaching processor that runs 32-bit instructions. It looks at the eleven most significant bits of the instruction word and, with no clock and no state, produces every steering signal the datapath needs for that instruction. These are the register-file write enable, the data-memory read and write enables, the ALU second-operand select, the write-back source select, a 4-bit ALU operation code, a 3-bit branch-kind code and a condition-flag update enable.

The opcode field has a different length in each instruction format: 11 bits for register (R) and data-transfer (D) forms, 10 for immediate (I), 8 for compare-and-branch (CB) and 6 for unconditional branch (B). The bits below each opcode hold operand data and are ignored. The assembler aliases MOV and CMP need no decode entries of their own: MOV is encoded as ADD and CMP as SUBS. Any opcode outside the supported set yields controls that cannot change architectural state.

Top module: `insn_ctl_decoder`

## Requirements
- R1: The opcode is instruction bits [31:21]. Bits [20:0] never change any output.
- R2: The exact 11-bit opcodes are ADD 10001011000, SUBS 11101011000, LSL 11010011011, BR 11010110000, MUL 10011011000, STUR 11111000000 and LDUR 11111000010. An opcode that differs from one of them only in its lowest bit is unrecognised.
- R3: These prefixes match whatever follows them: ADDI 1001000100, SUBI 1101000100, SUBIS 1111000100 (10 bits), B.cond 01010100, CBZ 10110100, CBNZ 10110101 (8 bits), and B 000101, BL 100101 (6 bits).
- R4: `reg_wr` is 1 only for ADD, SUBS, LSL, MUL, ADDI, SUBI, SUBIS, LDUR and BL. `wb_sel` is 00 for the ALU result, 01 for memory data (LDUR only) and 10 for the return link (BL only).
- R5: `mem_rd` is 1 only for LDUR and `mem_wr` only for STUR. `alu_src` is 1 (instruction immediate) for ADDI, SUBI, SUBIS, LSL, LDUR and STUR, and 0 otherwise.
- R6: `alu_op` uses ADD 0010, SUB 0110, MUL 0011, LSL 1000, PASS 0111 and NONE 1111. Loads and stores use ADD. SUBS, SUBI and SUBIS use SUB. BR, CBZ and CBNZ pass the register through. B, BL and B.cond use NONE.
- R7: `br_kind` is 000 for no branch, 001 for B and BL, 010 for B.cond, 011 for CBZ, 100 for CBNZ and 101 for BR. The hold code 110 is never produced.
- R8: `flag_wr` is 1 only for SUBS and SUBIS.
- R9: An unrecognised opcode gives `reg_wr`, `mem_rd`, `mem_wr`, `alu_src`, `flag_wr` all 0, `wb_sel` 00, `br_kind` 000 and `alu_op` 1111.
- R10: MOV, encoded as ADD, and CMP, encoded as SUBS with destination register 31, produce exactly the ADD and SUBS controls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn | input | 32 | Instruction word; only [31:21] is decoded |
| reg_wr | output | 1 | Register-file write enable |
| mem_rd | output | 1 | Data-memory read enable |
| mem_wr | output | 1 | Data-memory write enable |
| alu_src | output | 1 | ALU operand B: 0 register, 1 immediate |
| wb_sel | output | 2 | Write-back source: 00 ALU, 01 memory, 10 link |
| alu_op | output | 4 | ALU operation code |
| br_kind | output | 3 | Next-PC selection kind |
| flag_wr | output | 1 | Condition-flag update enable |

## Verification
The embedded checks assume that the instruction word is settled, two-state data whenever they evaluate. The bench meets this by changing `insn` only on the falling clock edge and reading the outputs one nanosecond later, so every sample sees a settled word. The checks also assume that the opcode patterns never overlap. The bench therefore drives every supported pattern and several near-miss neighbours. A match on two entries at once would trip the one-hot check, and an unsupported word that happened to match an entry would show up as wrong controls.

// File: rtl/insn_ctl_pkg.sv
package insn_ctl_pkg;

   localparam int CTL_OPC_W = 11;
   localparam int CTL_NCLS  = 15;

   typedef enum logic [3:0] {
      ALU_AND  = 4'b0000,
      ALU_OR   = 4'b0001,
      ALU_ADD  = 4'b0010,
      ALU_MUL  = 4'b0011,
      ALU_XOR  = 4'b0100,
      ALU_SUB  = 4'b0110,
      ALU_PASS = 4'b0111,
      ALU_LSL  = 4'b1000,
      ALU_LSR  = 4'b1001,
      ALU_NOR  = 4'b1100,
      ALU_NONE = 4'b1111
   } alu_op_e;

   typedef enum logic [2:0] {
      BRK_NONE   = 3'b000,
      BRK_UNCOND = 3'b001,
      BRK_FLAGS  = 3'b010,
      BRK_ZERO   = 3'b011,
      BRK_NZERO  = 3'b100,
      BRK_REG    = 3'b101,
      BRK_HOLD   = 3'b110
   } br_kind_e;

   typedef enum logic [1:0] {
      WB_ALU  = 2'b00,
      WB_MEM  = 2'b01,
      WB_LINK = 2'b10
   } wb_sel_e;

   typedef struct packed {
      logic     reg_wr;
      logic     mem_rd;
      logic     mem_wr;
      logic     alu_src;
      wb_sel_e  wb_sel;
      alu_op_e  alu_op;
      br_kind_e br_kind;
      logic     flag_wr;
   } ctl_t;

   // Decode classes; index order is the table order
   localparam int K_ADD   = 0;
   localparam int K_SUBS  = 1;
   localparam int K_LSL   = 2;
   localparam int K_BR    = 3;
   localparam int K_MUL   = 4;
   localparam int K_STUR  = 5;
   localparam int K_LDUR  = 6;
   localparam int K_ADDI  = 7;
   localparam int K_SUBI  = 8;
   localparam int K_SUBIS = 9;
   localparam int K_B     = 10;
   localparam int K_BL    = 11;
   localparam int K_BCOND = 12;
   localparam int K_CBZ   = 13;
   localparam int K_CBNZ  = 14;

   // Opcode pattern, left-aligned in 11 bits, don't-care bits zero
   function automatic logic [CTL_OPC_W-1:0] cls_pat(input int k);
      case (k)
         K_ADD:   return 11'b10001011000;
         K_SUBS:  return 11'b11101011000;
         K_LSL:   return 11'b11010011011;
         K_BR:    return 11'b11010110000;
         K_MUL:   return 11'b10011011000;
         K_STUR:  return 11'b11111000000;
         K_LDUR:  return 11'b11111000010;
         K_ADDI:  return 11'b10010001000;
         K_SUBI:  return 11'b11010001000;
         K_SUBIS: return 11'b11110001000;
         K_B:     return 11'b00010100000;
         K_BL:    return 11'b10010100000;
         K_BCOND: return 11'b01010100000;
         K_CBZ:   return 11'b10110100000;
         K_CBNZ:  return 11'b10110101000;
         default: return '0;
      endcase
   endfunction

   // Number of significant opcode bits for each class
   function automatic int cls_len(input int k);
      case (k)
         K_ADDI, K_SUBI, K_SUBIS: return 10;
         K_BCOND, K_CBZ, K_CBNZ:  return 8;
         K_B, K_BL:               return 6;
         default:                 return 11;
      endcase
   endfunction

   localparam ctl_t CTL_SAFE = '{
      reg_wr: 1'b0, mem_rd: 1'b0, mem_wr: 1'b0, alu_src: 1'b0,
      wb_sel: WB_ALU, alu_op: ALU_NONE, br_kind: BRK_NONE, flag_wr: 1'b0};

endpackage

// File: rtl/opc_match.sv
module opc_match
   import insn_ctl_pkg::*;
#(
   parameter int OPC_W = CTL_OPC_W,
   parameter int NCLS  = CTL_NCLS
)(
   input  logic [OPC_W-1:0] opc,
   output logic [NCLS-1:0]  hit
);

   localparam logic [OPC_W-1:0] ALL_ONES = '1;

   if (OPC_W != CTL_OPC_W) begin : g_bad_w
      $error("opc_match: OPC_W must equal the pattern width");
   end
   if (NCLS > CTL_NCLS || NCLS < 1) begin : g_bad_n
      $error("opc_match: NCLS out of range");
   end

   for (genvar k = 0; k < NCLS; k++) begin : g_cls
      localparam int               LEN  = cls_len(k);
      localparam logic [OPC_W-1:0] MASK = ~(ALL_ONES >> LEN);
      localparam logic [OPC_W-1:0] PAT  = cls_pat(k);
      assign hit[k] = ((opc & MASK) == PAT);
   end

endmodule

// File: rtl/cls_encode.sv
module cls_encode #(
   parameter int NCLS     = 15,
   parameter int IDX_W    = $clog2(NCLS),
   parameter bit PRIORITY = 1'b0
)(
   input  logic [NCLS-1:0]  hit,
   output logic [IDX_W-1:0] idx,
   output logic             any
);

   if (IDX_W < $clog2(NCLS)) begin : g_bad_idx
      $error("cls_encode: IDX_W too narrow");
   end

   assign any = |hit;

   if (PRIORITY) begin : g_prio
      // Lowest index wins if patterns ever overlap
      always_comb begin
         idx = '0;
         for (int i = NCLS - 1; i >= 0; i--) begin
            if (hit[i]) idx = IDX_W'(i);
         end
      end
   end else begin : g_or
      // Disjoint patterns: plain OR of the active index
      always_comb begin
         idx = '0;
         for (int i = 0; i < NCLS; i++) begin
            idx = idx | (hit[i] ? IDX_W'(i) : '0);
         end
      end
   end

endmodule

// File: rtl/ctl_table.sv
module ctl_table
   import insn_ctl_pkg::*;
#(
   parameter int IDX_W = 4
)(
   input  logic [IDX_W-1:0] idx,
   input  logic             any,
   output ctl_t             ctl
);

   always_comb begin
      ctl = CTL_SAFE;
      if (any) begin
         case (int'(idx))
            K_ADD: begin
               ctl.reg_wr = 1'b1; ctl.alu_op = ALU_ADD;
            end
            K_SUBS: begin
               ctl.reg_wr = 1'b1; ctl.alu_op = ALU_SUB; ctl.flag_wr = 1'b1;
            end
            K_LSL: begin
               ctl.reg_wr = 1'b1; ctl.alu_src = 1'b1; ctl.alu_op = ALU_LSL;
            end
            K_BR: begin
               ctl.alu_op = ALU_PASS; ctl.br_kind = BRK_REG;
            end
            K_MUL: begin
               ctl.reg_wr = 1'b1; ctl.alu_op = ALU_MUL;
            end
            K_STUR: begin
               ctl.mem_wr = 1'b1; ctl.alu_src = 1'b1; ctl.alu_op = ALU_ADD;
            end
            K_LDUR: begin
               ctl.reg_wr = 1'b1; ctl.mem_rd = 1'b1; ctl.alu_src = 1'b1;
               ctl.wb_sel = WB_MEM; ctl.alu_op = ALU_ADD;
            end
            K_ADDI: begin
               ctl.reg_wr = 1'b1; ctl.alu_src = 1'b1; ctl.alu_op = ALU_ADD;
            end
            K_SUBI: begin
               ctl.reg_wr = 1'b1; ctl.alu_src = 1'b1; ctl.alu_op = ALU_SUB;
            end
            K_SUBIS: begin
               ctl.reg_wr = 1'b1; ctl.alu_src = 1'b1; ctl.alu_op = ALU_SUB;
               ctl.flag_wr = 1'b1;
            end
            K_B: begin
               ctl.br_kind = BRK_UNCOND;
            end
            K_BL: begin
               ctl.reg_wr = 1'b1; ctl.wb_sel = WB_LINK; ctl.br_kind = BRK_UNCOND;
            end
            K_BCOND: begin
               ctl.br_kind = BRK_FLAGS;
            end
            K_CBZ: begin
               ctl.alu_op = ALU_PASS; ctl.br_kind = BRK_ZERO;
            end
            K_CBNZ: begin
               ctl.alu_op = ALU_PASS; ctl.br_kind = BRK_NZERO;
            end
            default: ctl = CTL_SAFE;
         endcase
      end
   end

endmodule

// File: rtl/insn_ctl_decoder.sv
module insn_ctl_decoder
   import insn_ctl_pkg::*;
#(
   parameter int INSN_W   = 32,
   parameter int OPC_W    = CTL_OPC_W,
   parameter bit PRIORITY = 1'b0
)(
   input  logic [INSN_W-1:0] insn,
   output logic              reg_wr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              alu_src,
   output logic [1:0]        wb_sel,
   output logic [3:0]        alu_op,
   output logic [2:0]        br_kind,
   output logic              flag_wr
);

   localparam int OPC_LSB = INSN_W - OPC_W;
   localparam int NCLS    = CTL_NCLS;
   localparam int IDX_W   = $clog2(NCLS);

   if (OPC_W != CTL_OPC_W || OPC_LSB < 1) begin : g_bad_cfg
      $error("insn_ctl_decoder: unsupported INSN_W/OPC_W");
   end

   logic [OPC_W-1:0] opc;
   logic [NCLS-1:0]  hit;
   logic [IDX_W-1:0] idx;
   logic             any;
   ctl_t             ctl;
   logic             unused_low;

   assign opc        = insn[INSN_W-1:OPC_LSB];
   assign unused_low = ^insn[OPC_LSB-1:0];

   opc_match #(.OPC_W(OPC_W), .NCLS(NCLS)) u_match (
      .opc(opc),
      .hit(hit)
   );

   cls_encode #(.NCLS(NCLS), .IDX_W(IDX_W), .PRIORITY(PRIORITY)) u_enc (
      .hit(hit),
      .idx(idx),
      .any(any)
   );

   ctl_table #(.IDX_W(IDX_W)) u_tab (
      .idx(idx),
      .any(any),
      .ctl(ctl)
   );

   assign reg_wr  = ctl.reg_wr;
   assign mem_rd  = ctl.mem_rd;
   assign mem_wr  = ctl.mem_wr;
   assign alu_src = ctl.alu_src;
   assign wb_sel  = ctl.wb_sel;
   assign alu_op  = ctl.alu_op;
   assign br_kind = ctl.br_kind;
   assign flag_wr = ctl.flag_wr;

   always_comb begin
      if (!$isunknown(insn)) begin
         // R2
         pattern_disjoint_chk: assert ($onehot0(hit))
            else $error("opcode matched more than one class");
         // R9
         unknown_safe_chk: assert (any || (!reg_wr && !mem_rd && !mem_wr &&
                                   !flag_wr && br_kind == BRK_NONE &&
                                   alu_op == ALU_NONE))
            else $error("unrecognised opcode produced active controls");
         // R5
         mem_excl_chk: assert (!(mem_rd && mem_wr))
            else $error("memory read and write together");
         // R4
         load_wb_chk: assert (!mem_rd || (reg_wr && wb_sel == WB_MEM))
            else $error("load without memory write-back");
         // R6
         mem_addr_chk: assert (!(mem_rd || mem_wr) ||
                               (alu_op == ALU_ADD && alu_src))
            else $error("memory access without base+offset");
         // R8
         flag_sub_chk: assert (!flag_wr || alu_op == ALU_SUB)
            else $error("flag update on non-subtract");
         // R7
         no_hold_chk: assert (br_kind != BRK_HOLD)
            else $error("hold branch kind produced");
         // R4
         link_branch_chk: assert (wb_sel != WB_LINK ||
                                  (reg_wr && br_kind == BRK_UNCOND))
            else $error("link write-back outside a call");
      end
   end

endmodule

// File: tb/sim_insn_ctl_decoder.sv
`timescale 1ns/1ps
module sim_insn_ctl_decoder;

   logic        clk = 1'b0;
   logic [31:0] insn;
   logic        reg_wr, mem_rd, mem_wr, alu_src, flag_wr;
   logic [1:0]  wb_sel;
   logic [3:0]  alu_op;
   logic [2:0]  br_kind;

   int  n_chk = 0;
   int  n_err = 0;
   bit  done  = 1'b0;

   always #2.5 clk = ~clk;

   insn_ctl_decoder u0 (
      .insn(insn), .reg_wr(reg_wr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .alu_src(alu_src), .wb_sel(wb_sel), .alu_op(alu_op),
      .br_kind(br_kind), .flag_wr(flag_wr)
   );

   // Packed order: reg_wr mem_rd mem_wr alu_src wb_sel alu_op br_kind flag_wr
   localparam logic [13:0] E_ADD   = 14'b1_0_0_0_00_0010_000_0;
   localparam logic [13:0] E_SUBS  = 14'b1_0_0_0_00_0110_000_1;
   localparam logic [13:0] E_LSL   = 14'b1_0_0_1_00_1000_000_0;
   localparam logic [13:0] E_BR    = 14'b0_0_0_0_00_0111_101_0;
   localparam logic [13:0] E_MUL   = 14'b1_0_0_0_00_0011_000_0;
   localparam logic [13:0] E_STUR  = 14'b0_0_1_1_00_0010_000_0;
   localparam logic [13:0] E_LDUR  = 14'b1_1_0_1_01_0010_000_0;
   localparam logic [13:0] E_ADDI  = 14'b1_0_0_1_00_0010_000_0;
   localparam logic [13:0] E_SUBI  = 14'b1_0_0_1_00_0110_000_0;
   localparam logic [13:0] E_SUBIS = 14'b1_0_0_1_00_0110_000_1;
   localparam logic [13:0] E_B     = 14'b0_0_0_0_00_1111_001_0;
   localparam logic [13:0] E_BL    = 14'b1_0_0_0_10_1111_001_0;
   localparam logic [13:0] E_BCOND = 14'b0_0_0_0_00_1111_010_0;
   localparam logic [13:0] E_CBZ   = 14'b0_0_0_0_00_0111_011_0;
   localparam logic [13:0] E_CBNZ  = 14'b0_0_0_0_00_0111_100_0;
   localparam logic [13:0] E_SAFE  = 14'b0_0_0_0_00_1111_000_0;

   task automatic apply_and_check(input string tag, input logic [31:0] word,
                                  input logic [13:0] exp);
      logic [13:0] act;
      @(negedge clk);
      insn = word;
      #1;
      act = {reg_wr, mem_rd, mem_wr, alu_src, wb_sel, alu_op, br_kind, flag_wr};
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s insn=%h actual=%b expected=%b", tag, word, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic [10:0] opc, input logic [20:0] low);
      return {opc, low};
   endfunction

   task automatic t_idle();
      // R9: all-zero word is no supported opcode
      apply_and_check("R9 idle zero word", 32'h0, E_SAFE);
   endtask

   task automatic t_exact();
      apply_and_check("R2 ADD",  mk(11'b10001011000, 21'h0A5C3), E_ADD);
      apply_and_check("R2 SUBS", mk(11'b11101011000, 21'h01234), E_SUBS);
      apply_and_check("R2 LSL",  mk(11'b11010011011, 21'h00F0F), E_LSL);
      apply_and_check("R2 BR",   mk(11'b11010110000, 21'h003C0), E_BR);
      apply_and_check("R2 MUL",  mk(11'b10011011000, 21'h1FC21), E_MUL);
      apply_and_check("R5 STUR", mk(11'b11111000000, 21'h12345), E_STUR);
      apply_and_check("R4 LDUR", mk(11'b11111000010, 21'h0ABCD), E_LDUR);
   endtask

   task automatic t_near_miss();
      apply_and_check("R2 ADD lsb flip",  mk(11'b10001011001, 21'h0), E_SAFE);
      apply_and_check("R2 STUR lsb flip", mk(11'b11111000001, 21'h0), E_SAFE);
      apply_and_check("R2 LSL lsb flip",  mk(11'b11010011010, 21'h0), E_SAFE);
      apply_and_check("R9 all ones",      32'hFFFF_FFFF,              E_SAFE);
   endtask

   task automatic t_dont_care();
      for (int b = 0; b < 2; b++) begin
         apply_and_check("R3 ADDI",  mk({10'b1001000100, 1'(b)}, 21'h055), E_ADDI);
         apply_and_check("R3 SUBI",  mk({10'b1101000100, 1'(b)}, 21'h0AA), E_SUBI);
         apply_and_check("R8 SUBIS", mk({10'b1111000100, 1'(b)}, 21'h1FF), E_SUBIS);
      end
      for (int v = 0; v < 8; v += 7) begin
         apply_and_check("R7 B.cond", mk({8'b01010100, 3'(v)}, 21'h00D), E_BCOND);
         apply_and_check("R7 CBZ",    mk({8'b10110100, 3'(v)}, 21'h100), E_CBZ);
         apply_and_check("R7 CBNZ",   mk({8'b10110101, 3'(v)}, 21'h003), E_CBNZ);
      end
      apply_and_check("R3 B low zero",  mk(11'b00010100000, 21'h0),      E_B);
      apply_and_check("R3 B low ones",  mk(11'b00010111111, 21'h1FFFFF), E_B);
      apply_and_check("R4 BL link",     mk(11'b10010110101, 21'h0F0F0),  E_BL);
   endtask

   task automatic t_low_bits();
      // R1: operand bits never change controls
      apply_and_check("R1 ADD low zero", mk(11'b10001011000, 21'h000000), E_ADD);
      apply_and_check("R1 ADD low ones", mk(11'b10001011000, 21'h1FFFFF), E_ADD);
      apply_and_check("R1 LDUR low ones", mk(11'b11111000010, 21'h1FFFFF), E_LDUR);
   endtask

   task automatic t_alias();
      // R10: MOV Xd,Xm as ADD Xd,XZR,Xm ; CMP Xn,Xm as SUBS XZR,Xn,Xm
      apply_and_check("R10 MOV",  {11'b10001011000, 5'd7, 6'd0, 5'd31, 5'd3}, E_ADD);
      apply_and_check("R10 CMP",  {11'b11101011000, 5'd4, 6'd0, 5'd9, 5'd31}, E_SUBS);
      apply_and_check("R6 MUL op", mk(11'b10011011000, 21'h0), E_MUL);
   endtask

   initial begin
      #50000;
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: run did not complete (all requirements)");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      insn = '0;
      repeat (2) @(posedge clk);
      t_idle();
      t_exact();
      t_near_miss();
      t_dont_care();
      t_low_bits();
      t_alias();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule